// File: doc/BRIEF.md
# Leaf Page-Entry Access Fault Checker

This block decides, in one combinational pass, whether a memory access that resolved to a given leaf page-table entry must trap as a page fault. A translation unit presents the 32-bit entry, the level of the table the entry was read from, the kind of access, the current privilege, and the two status controls. These controls are user-page access from supervisor mode and making executable pages readable for loads. The block returns a fault flag and a three-bit cause code that tells software which rule was broken.

The entry layout is: valid at bit 0, readable at bit 1, writable at bit 2, executable at bit 3, and user-accessible at bit 4. The physical page number occupies bits 31:10. Bits 9:8 are reserved by default and must be zero. When several rules are broken, the cause reports the one highest in a fixed priority order. The block has no state, so its result is valid in the same cycle its inputs are.

Top module: `ptechk_top`

## Requirements
- R1: With valid bit 0 clear, fault_o is 1 and cause_o is 1, whatever the other inputs are.
- R2: If any bit under the reserved mask is set (default: pte bits 9:8), the access faults with cause 2.
- R3: An entry with writable (bit 2) set and readable (bit 1) clear faults with cause 3.
- R4: At level 0, an entry with none of bits 3:1 set faults with cause 4; at level 1 such an entry is not given cause 4.
- R5: In user mode (priv_i = 0), an entry with bit 4 clear faults with cause 5; with bit 4 set the privilege rule passes.
- R6: In supervisor mode (priv_i = 1), an entry with bit 4 set faults with cause 5 when sum_i = 0. When sum_i = 1, loads and stores pass this rule, but a fetch still faults with cause 5.
- R7: At level 1, an entry whose pte bits 19:10 are not all zero faults with cause 6; at level 0 those bits are not checked.
- R8: A load (access_i = 0) passes the permission rule when readable is set, or when executable is set and mxr_i = 1; otherwise it faults with cause 7.
- R9: A store (access_i = 1) passes the permission rule only when both readable and writable are set; otherwise it faults with cause 7.
- R10: A fetch (access_i = 2) passes the permission rule exactly when executable is set. Access code 3 always fails this rule with cause 7.
- R11: Causes rank 1 > 2 > 3 > 4 > 5 > 6 > 7. fault_o is 1 exactly when cause_o is nonzero, and cause_o is 0 when every rule passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pte_i | input | 32 | Leaf page-table entry under test |
| level_i | input | LVL_W (1) | Table level the entry came from, 0 = smallest page |
| access_i | input | 2 | 0 load, 1 store, 2 instruction fetch, 3 unused code |
| priv_i | input | 1 | 0 user, 1 supervisor |
| sum_i | input | 1 | Supervisor may touch user pages |
| mxr_i | input | 1 | Loads may read executable pages |
| fault_o | output | 1 | Access must raise a page fault |
| cause_o | output | 3 | Highest-priority broken rule, 0 when none |

## Verification
The bench sweeps all combinations of readable, writable, executable, user, SUM, MXR, privilege, access code and level, so any entry mixed up in the load, store or fetch tables shows up as a wrong cause. Directed vectors focus on ordering. An invalid entry with reserved bits set must report invalid. A pointer-like entry at level 0 must report non-leaf rather than privilege. A design that ranked these rules in the wrong order would return a different nonzero cause. Separate vectors cover three more cases. A misaligned large page must fault only at level 1. A supervisor fetch from a user page must fault even with SUM set. A design that let SUM open execution, or checked alignment at level 0, would return 0 or 6 where 5 or 0 is expected.

// File: rtl/ptechk_pkg.sv
package ptechk_pkg;

    localparam int PTE_W   = 32;
    localparam int PPN_LSB = 10;
    localparam int PPN_W   = PTE_W - PPN_LSB;

    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_U = 4;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } access_e;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_INVALID  = 3'd1,
        CAUSE_RSVD     = 3'd2,
        CAUSE_WNOR     = 3'd3,
        CAUSE_NOLEAF   = 3'd4,
        CAUSE_PRIV     = 3'd5,
        CAUSE_MISALIGN = 3'd6,
        CAUSE_PERM     = 3'd7
    } cause_e;

    typedef struct packed {
        logic   fault;
        cause_e cause;
    } verdict_t;

endpackage

// File: rtl/ptechk_format.sv
module ptechk_format
    import ptechk_pkg::*;
#(
    parameter int                LEVELS    = 2,
    parameter int                VPN_W     = 10,
    parameter logic [PTE_W-1:0]  RSVD_MASK = 32'h0000_0300,
    localparam int               LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [PTE_W-1:0] pte_i,
    input  logic [LVL_W-1:0] level_i,
    output logic             valid_o,
    output logic             rsvd_o,
    output logic             wnor_o,
    output logic             noleaf_o,
    output logic             misalign_o
);

    logic [PPN_W-1:0]  ppn;
    logic [LEVELS-1:0] mis_per_lvl;
    logic              rwx_none;

    assign ppn      = pte_i[PTE_W-1:PPN_LSB];
    assign rwx_none = ~(pte_i[BIT_R] | pte_i[BIT_W] | pte_i[BIT_X]);

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        if (l == 0) begin : g_base
            assign mis_per_lvl[l] = 1'b0;
        end else begin : g_super
            localparam int               SH       = l * VPN_W;
            localparam logic [PPN_W-1:0] LOW_MASK = PPN_W'((64'd1 << SH) - 64'd1);
            assign mis_per_lvl[l] = |(ppn & LOW_MASK);
        end
    end

    always_comb begin
        valid_o    = pte_i[BIT_V];
        rsvd_o     = |(pte_i & RSVD_MASK);
        wnor_o     = pte_i[BIT_W] & ~pte_i[BIT_R];
        noleaf_o   = (level_i == '0) & rwx_none;
        misalign_o = 1'b0;
        if (int'(level_i) < LEVELS) begin
            misalign_o = mis_per_lvl[level_i];
        end
    end

endmodule

// File: rtl/ptechk_access.sv
module ptechk_access
    import ptechk_pkg::*;
(
    input  logic       r_i,
    input  logic       w_i,
    input  logic       x_i,
    input  logic       u_i,
    input  logic [1:0] access_i,
    input  logic       priv_i,
    input  logic       sum_i,
    input  logic       mxr_i,
    output logic       priv_fault_o,
    output logic       perm_fault_o
);

    access_e acc;
    assign acc = access_e'(access_i);

    always_comb begin
        if (!priv_i) begin
            priv_fault_o = ~u_i;
        end else begin
            priv_fault_o = u_i & (~sum_i | (acc == ACC_FETCH));
        end
    end

    always_comb begin
        unique case (acc)
            ACC_LOAD:  perm_fault_o = ~(r_i | (x_i & mxr_i));
            ACC_STORE: perm_fault_o = ~(r_i & w_i);
            ACC_FETCH: perm_fault_o = ~x_i;
            default:   perm_fault_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/ptechk_top.sv
module ptechk_top
    import ptechk_pkg::*;
#(
    parameter int                LEVELS    = 2,
    parameter int                VPN_W     = 10,
    parameter logic [PTE_W-1:0]  RSVD_MASK = 32'h0000_0300,
    localparam int               LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [PTE_W-1:0] pte_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [1:0]       access_i,
    input  logic             priv_i,
    input  logic             sum_i,
    input  logic             mxr_i,
    output logic             fault_o,
    output logic [2:0]       cause_o
);

    logic valid, rsvd, wnor, noleaf, misalign;
    logic priv_fault, perm_fault;
    verdict_t verdict_d;

    ptechk_format #(
        .LEVELS   (LEVELS),
        .VPN_W    (VPN_W),
        .RSVD_MASK(RSVD_MASK)
    ) i_format (
        .pte_i     (pte_i),
        .level_i   (level_i),
        .valid_o   (valid),
        .rsvd_o    (rsvd),
        .wnor_o    (wnor),
        .noleaf_o  (noleaf),
        .misalign_o(misalign)
    );

    ptechk_access i_access (
        .r_i         (pte_i[BIT_R]),
        .w_i         (pte_i[BIT_W]),
        .x_i         (pte_i[BIT_X]),
        .u_i         (pte_i[BIT_U]),
        .access_i    (access_i),
        .priv_i      (priv_i),
        .sum_i       (sum_i),
        .mxr_i       (mxr_i),
        .priv_fault_o(priv_fault),
        .perm_fault_o(perm_fault)
    );

    always_comb begin
        verdict_d.cause = CAUSE_NONE;
        if (!valid)          verdict_d.cause = CAUSE_INVALID;
        else if (rsvd)       verdict_d.cause = CAUSE_RSVD;
        else if (wnor)       verdict_d.cause = CAUSE_WNOR;
        else if (noleaf)     verdict_d.cause = CAUSE_NOLEAF;
        else if (priv_fault) verdict_d.cause = CAUSE_PRIV;
        else if (misalign)   verdict_d.cause = CAUSE_MISALIGN;
        else if (perm_fault) verdict_d.cause = CAUSE_PERM;
        verdict_d.fault = (verdict_d.cause != CAUSE_NONE);
    end

    assign fault_o = verdict_d.fault;
    assign cause_o = verdict_d.cause;

endmodule

// File: rtl/ptechk_sva.sv
module ptechk_sva (
    input logic [31:0] pte_i,
    input logic [1:0]  access_i,
    input logic        priv_i,
    input logic        sum_i,
    input logic        mxr_i,
    input logic        fault_o,
    input logic [2:0]  cause_o
);

    always_comb begin
        if (!pte_i[0]) begin
            a_r1_invalid_faults: assert (fault_o && cause_o == 3'd1);
        end
        a_r11_flag_matches_cause: assert (fault_o == (cause_o != 3'd0));
        if (!fault_o && access_i == 2'd0) begin
            a_r8_load_needs_read: assert (pte_i[1] || (pte_i[3] && mxr_i));
        end
        if (!fault_o && access_i == 2'd1) begin
            a_r9_store_needs_rw: assert (pte_i[1] && pte_i[2]);
        end
        if (!fault_o && access_i == 2'd2) begin
            a_r10_fetch_needs_x: assert (pte_i[3]);
        end
        if (!fault_o && !priv_i) begin
            a_r5_user_needs_u: assert (pte_i[4]);
        end
        if (!fault_o && priv_i && pte_i[4]) begin
            a_r6_sup_user_page_needs_sum: assert (sum_i && access_i != 2'd2);
        end
    end

endmodule

bind ptechk_top ptechk_sva i_sva (
    .pte_i   (pte_i),
    .access_i(access_i),
    .priv_i  (priv_i),
    .sum_i   (sum_i),
    .mxr_i   (mxr_i),
    .fault_o (fault_o),
    .cause_o (cause_o)
);

// File: tb/test_ptechk_top.sv
module test_ptechk_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 20;

    typedef struct packed {
        logic [31:0] pte;
        logic        lvl;
        logic [1:0]  acc;
        logic        priv;
        logic        sum;
        logic        mxr;
        logic [2:0]  exp;
    } vec_t;

    // pte, level, access, priv, sum, mxr, expected cause
    localparam vec_t VECS [N_VEC] = '{
        '{32'h0000_0000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd1},  // R1
        '{32'h0000_030E, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd1},  // R11 invalid beats reserved
        '{32'h0000_030F, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd2},  // R2
        '{32'h0000_0105, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 3'd2},  // R11 reserved beats W-no-R
        '{32'h0000_0005, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 3'd3},  // R3
        '{32'h0000_0001, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd4},  // R4
        '{32'h0000_0011, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd4},  // R11 non-leaf beats priv
        '{32'h0000_0001, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd7},  // R4 not at level 1
        '{32'h0000_0003, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5},  // R5
        '{32'h0000_0013, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R5 user page ok
        '{32'h0000_0013, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd5},  // R6 SUM clear
        '{32'h0000_0013, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 3'd0},  // R6 SUM set
        '{32'h0000_0019, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 3'd5},  // R6 fetch never
        '{32'h0000_040B, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd6},  // R7
        '{32'h0010_000B, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0},  // R7 aligned
        '{32'h0000_040B, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0},  // R7 level 0 unchecked
        '{32'h0000_0009, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd7},  // R8 no MXR
        '{32'h0000_0009, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 3'd0},  // R8 MXR
        '{32'h0000_0003, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 3'd7},  // R9
        '{32'h0000_000F, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 3'd7}   // R10 code 3
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pte;
    logic        lvl;
    logic [1:0]  acc;
    logic        priv, sum, mxr;
    logic        fault;
    logic [2:0]  cause;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ptechk_top i_ptechk_top (
        .pte_i   (pte),
        .level_i (lvl),
        .access_i(acc),
        .priv_i  (priv),
        .sum_i   (sum),
        .mxr_i   (mxr),
        .fault_o (fault),
        .cause_o (cause)
    );

    function automatic logic [2:0] ref_cause(logic [31:0] p, logic l, logic [1:0] a,
                                             logic pv, logic sm, logic mx);
        logic r, w, x, u, bad;
        r = p[1]; w = p[2]; x = p[3]; u = p[4];
        if (!p[0])                     return 3'd1;
        if (p[9:8] != 2'b00)           return 3'd2;
        if (w && !r)                   return 3'd3;
        if (!l && !(r || w || x))      return 3'd4;
        if (!pv && !u)                 return 3'd5;
        if (pv && u && (!sm || a == 2'd2)) return 3'd5;
        if (l && p[19:10] != 10'd0)    return 3'd6;
        case (a)
            2'd0:    bad = !(r || (x && mx));
            2'd1:    bad = !(r && w);
            2'd2:    bad = !x;
            default: bad = 1'b1;
        endcase
        return bad ? 3'd7 : 3'd0;
    endfunction

    function automatic string tag_of(logic [2:0] c, logic [1:0] a);
        case (c)
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5/R6";
            3'd6: return "R7";
            3'd7: return (a == 2'd0) ? "R8" : (a == 2'd1) ? "R9" : "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check_one(logic [31:0] p, logic l, logic [1:0] a, logic pv,
                             logic sm, logic mx, logic [2:0] exp, string tag);
        @(negedge clk);
        pte = p; lvl = l; acc = a; priv = pv; sum = sm; mxr = mx;
        #1;
        checks++;
        if (cause !== exp || fault !== (exp != 3'd0)) begin
            errors++;
            $display("FAIL %s pte=%h lvl=%0d acc=%0d priv=%0d sum=%0d mxr=%0d: cause=%0d fault=%0d expected cause=%0d fault=%0d",
                     tag, p, l, a, pv, sm, mx, cause, fault, exp, exp != 3'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: run=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        pte = '0; lvl = 1'b0; acc = 2'd0; priv = 1'b0; sum = 1'b0; mxr = 1'b0;
        // R1: state while reset held and the entry is all zero
        check_one(32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1, "R1 reset");
        repeat (2) @(posedge clk);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            check_one(VECS[i].pte, VECS[i].lvl, VECS[i].acc, VECS[i].priv,
                      VECS[i].sum, VECS[i].mxr, VECS[i].exp,
                      tag_of(VECS[i].exp, VECS[i].acc));
        end

        // R11: exhaustive sweep of permission, privilege, status, access and level
        for (int k = 0; k < 1024; k++) begin
            logic [31:0] p;
            logic [9:0]  kb;
            logic [2:0]  e;
            kb = 10'(k);
            p  = {27'd0, kb[3], kb[2], kb[1], kb[0], 1'b1};
            e  = ref_cause(p, kb[7], kb[9:8], kb[6], kb[4], kb[5]);
            check_one(p, kb[7], kb[9:8], kb[6], kb[4], kb[5], e, tag_of(e, kb[9:8]));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule